// File: doc/BRIEF.md
# Program-Busy Read Status Generator

This block forms the read data path of a byte-wide non-volatile store that runs self-timed program cycles. While a program cycle runs, the host cannot read the array. It polls instead, and this block answers each poll with status bits. When the cycle ends, the block passes the true array data straight through. The write sequencer supplies three inputs: a busy flag, the address that was written last, and the byte that was written last. The host supplies the usual active-low strobes for chip select, output enable and write enable. The array supplies the stored byte for the current address.

Two completion indicators are given at the same time:
- **Polarity flag.** A poll of the last written location returns the inverted top bit of the written byte.
- **Flip flag.** A second bit changes value on every new read that starts while the cycle is busy.

Both flags turn into true data once busy drops. The bus-drive output and the read data are registered, so each appears one clock after the strobes are sampled. A host that holds a read for several clocks sees one stable value for the whole read.

Top module: `read_status_gen`

## Requirements
- R1: `bus_drive` is 1 in the cycle after the strobes show a read, meaning `we_n`=1, `ce_n`=0 and `oe_n`=0. At every other time it is 0, and `rd_data` is then all zeros.
- R2: On a read while `busy`=1 with `addr` equal to `last_addr`, bit 7 of `rd_data` is the inverse of bit 7 of `last_data`.
- R3: On a read while `busy`=1 with `addr` different from `last_addr`, bit 7 of `rd_data` equals bit 7 of `last_data`.
- R4: On a read while `busy`=1, bits 5 to 0 of `rd_data` equal the same bits of `last_data`.
- R5: On a read while `busy`=1, bit 6 of `rd_data` is the flip flag. It inverts once for each new read start, whether `ce_n` falls or `oe_n` falls. It stays constant for as long as one read is held.
- R6: A strobe pattern with `we_n`=0 is not a read. It does not drive the bus, and it does not advance the flip flag.
- R7: On a read while `busy`=0, `rd_data` equals `array_data`. While `busy`=0 the flip flag is cleared, so the first read of the next busy period shows bit 6 = 1.
- R8: `rd_data` and `bus_drive` take one clock of latency: they reflect the inputs sampled at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Read address |
| busy | input | 1 | Program cycle in progress |
| last_addr | input | 15 | Address of the last written byte |
| last_data | input | 8 | Last written byte |
| array_data | input | 8 | Stored byte for `addr` |
| rd_data | output | 8 | Read result, zero when not driving |
| bus_drive | output | 1 | Output-driver enable for the data bus |

## Verification
The hardest case is telling a held read apart from a new one. The flip flag must advance only on a read start, and it must ignore two things: the extra clocks of a held read, and strobe patterns that carry a write.

The stimulus reaches these cases in four ways:
- It holds one read over several clocks and checks that bit 6 stays stable.
- It inserts a write-strobe pulse between two polls and confirms the following poll continues the sequence unbroken.
- It alternates output enable while chip select stays low, to show that either strobe can start a read.
- It ends a busy period and starts a new one, to show the flip flag restarts from a cleared state.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   // How status-read bits that carry no flag are filled while busy
   typedef enum logic [0:0] {
      FILL_LAST_DATA = 1'b0,
      FILL_ZERO      = 1'b1
   } fill_mode_e;
endpackage

// File: rtl/rsg_strobe.sv
// Read qualification and read-start detection
module rsg_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic rd_act,
   output logic rd_start,
   output logic rd_act_q
);
   always_comb begin
      rd_act   = we_n & ~ce_n & ~oe_n;
      rd_start = rd_act & ~rd_act_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_act_q <= 1'b0;
      else        rd_act_q <= rd_act;
   end
endmodule

// File: rtl/rsg_toggle.sv
// Flip flag: inverts on each read start while busy, cleared when idle
module rsg_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_start,
   output logic tgl_nxt
);
   logic tgl_q;

   always_comb begin
      if (!busy)         tgl_nxt = 1'b0;
      else if (rd_start) tgl_nxt = ~tgl_q;
      else               tgl_nxt = tgl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= tgl_nxt;
   end
endmodule

// File: rtl/rsg_compose.sv
// Builds the byte returned by a read: status while busy, array data otherwise
module rsg_compose
   import rsg_pkg::*;
#(
   parameter int         AW         = 15,
   parameter int         DW         = 8,
   parameter int         POLL_BIT   = 7,
   parameter int         TOGGLE_BIT = 6,
   parameter fill_mode_e FILL       = FILL_LAST_DATA
) (
   input  logic [AW-1:0] addr,
   input  logic          busy,
   input  logic [AW-1:0] last_addr,
   input  logic [DW-1:0] last_data,
   input  logic [DW-1:0] array_data,
   input  logic          tgl,
   output logic [DW-1:0] word
);
   logic [DW-1:0] fill;
   logic          hit;

   generate
      if (FILL == FILL_ZERO) begin : g_fill_zero
         assign fill = '0;
      end else begin : g_fill_last
         assign fill = last_data;
      end
   endgenerate

   always_comb begin
      hit = (addr == last_addr);
      if (busy) begin
         word             = fill;
         word[POLL_BIT]   = hit ? ~last_data[POLL_BIT] : last_data[POLL_BIT];
         word[TOGGLE_BIT] = tgl;
      end else begin
         word = array_data;
      end
   end
endmodule

// File: rtl/read_status_gen.sv
module read_status_gen
   import rsg_pkg::*;
#(
   parameter int         AW         = 15,
   parameter int         DW         = 8,
   parameter int         POLL_BIT   = 7,
   parameter int         TOGGLE_BIT = 6,
   parameter fill_mode_e FILL       = FILL_LAST_DATA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic          busy,
   input  logic [AW-1:0] last_addr,
   input  logic [DW-1:0] last_data,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] rd_data,
   output logic          bus_drive
);
   localparam int FLAG_BITS = 2;

   generate
      if (DW < FLAG_BITS || POLL_BIT >= DW || TOGGLE_BIT >= DW) begin : g_bad_width
         $error("read_status_gen: flag bit positions must lie inside DW");
      end
      if (POLL_BIT == TOGGLE_BIT) begin : g_bad_bits
         $error("read_status_gen: polarity and flip flags need distinct bits");
      end
      if (AW < 1) begin : g_bad_aw
         $error("read_status_gen: AW must be positive");
      end
   endgenerate

   logic          rd_act, rd_start, rd_act_q, tgl_nxt;
   logic [DW-1:0] word;

   rsg_strobe u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .rd_act   (rd_act),
      .rd_start (rd_start),
      .rd_act_q (rd_act_q)
   );

   rsg_toggle u_toggle (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .rd_start (rd_start),
      .tgl_nxt  (tgl_nxt)
   );

   rsg_compose #(
      .AW         (AW),
      .DW         (DW),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT),
      .FILL       (FILL)
   ) u_compose (
      .addr       (addr),
      .busy       (busy),
      .last_addr  (last_addr),
      .last_data  (last_data),
      .array_data (array_data),
      .tgl        (tgl_nxt),
      .word       (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data   <= '0;
         bus_drive <= 1'b0;
      end else begin
         bus_drive <= rd_act;
         rd_data   <= rd_act ? word : '0;
      end
   end
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
   parameter int AW         = 15,
   parameter int DW         = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          oe_n,
   input logic          we_n,
   input logic [AW-1:0] addr,
   input logic          busy,
   input logic [AW-1:0] last_addr,
   input logic [DW-1:0] last_data,
   input logic [DW-1:0] array_data,
   input logic [DW-1:0] rd_data,
   input logic          bus_drive
);
   logic is_rd;
   assign is_rd = we_n & ~ce_n & ~oe_n;

   AST_DRIVE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bus_drive == $past(is_rd))); // R1

   AST_QUIET_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_drive |-> (rd_data == '0)); // R1

   AST_POLL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && busy && addr == last_addr) |=> (rd_data[POLL_BIT] == ~$past(last_data[POLL_BIT]))); // R2

   AST_IDLE_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !busy) |=> (rd_data == $past(array_data))); // R7

   AST_HELD_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && bus_drive && busy && $past(busy)) |=> $stable(rd_data[TOGGLE_BIT])); // R5
endmodule

bind read_status_gen rsg_checker #(
   .AW         (AW),
   .DW         (DW),
   .POLL_BIT   (POLL_BIT),
   .TOGGLE_BIT (TOGGLE_BIT)
) u_rsg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .we_n       (we_n),
   .addr       (addr),
   .busy       (busy),
   .last_addr  (last_addr),
   .last_data  (last_data),
   .array_data (array_data),
   .rd_data    (rd_data),
   .bus_drive  (bus_drive)
);

// File: tb/read_status_gen_test.sv
`timescale 1ns/1ps
module read_status_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [14:0] addr = '0, last_addr = '0;
   logic        busy = 1'b0;
   logic [7:0]  last_data = '0, array_data = '0;
   logic [7:0]  rd_data;
   logic        bus_drive;

   int checks = 0;
   int errors = 0;
   logic tgl_m = 1'b0;   // bench model of the flip flag

   always #2.5 clk = ~clk;

   read_status_gen uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .busy(busy), .last_addr(last_addr), .last_data(last_data),
      .array_data(array_data), .rd_data(rd_data), .bus_drive(bus_drive)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_busy(input logic [14:0] a, input logic t);
      logic [7:0] w;
      w = last_data;
      w[7] = (a == last_addr) ? ~last_data[7] : last_data[7];
      w[6] = t;
      return w;
   endfunction

   // One complete read: start, sample, release, confirm bus released
   task automatic do_read(input logic [14:0] a, input string req);
      logic [7:0] exp;
      @(negedge clk);
      addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
      if (busy) begin tgl_m = ~tgl_m; exp = expect_busy(a, tgl_m); end
      else begin tgl_m = 1'b0; exp = array_data; end
      @(posedge clk); #1;
      check({req, " drive"}, {7'd0, bus_drive}, 8'd1);
      check(req, rd_data, exp);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      @(posedge clk); #1;
      check("R1 release", {7'd0, bus_drive}, 8'd0);
      check("R1 zero", rd_data, 8'd0);
   endtask

   task automatic t_reset;
      @(posedge clk); #1;
      check("R1 reset drive", {7'd0, bus_drive}, 8'd0);
      check("R1 reset data", rd_data, 8'd0);
   endtask

   task automatic t_idle_reads;
      busy = 1'b0; array_data = 8'h5A;
      do_read(15'h0100, "R7 idle true data");
      array_data = 8'hC3;
      do_read(15'h7FFF, "R8 idle latency");
   endtask

   task automatic t_write_strobe;
      @(negedge clk);
      we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
      @(posedge clk); #1;
      check("R6 write no drive", {7'd0, bus_drive}, 8'd0);
      check("R6 write zero", rd_data, 8'd0);
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic t_poll;
      @(negedge clk);
      busy = 1'b1; last_addr = 15'h0123; last_data = 8'hC5; tgl_m = 1'b0;
      do_read(15'h0123, "R2 poll match first");
      do_read(15'h0123, "R5 poll match second");
      do_read(15'h0400, "R3 poll other addr");
      last_data = 8'h3A;
      do_read(15'h0123, "R4 low bits");
      do_read(15'h0777, "R3 other addr low top");
   endtask

   task automatic t_held_read;
      logic [7:0] exp;
      @(negedge clk);
      addr = 15'h0123; ce_n = 1'b0; oe_n = 1'b0;
      tgl_m = ~tgl_m; exp = expect_busy(15'h0123, tgl_m);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         check("R5 held read stable", rd_data, exp);
      end
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic t_write_between_polls;
      t_write_strobe;
      do_read(15'h0123, "R6 no advance after write");
   endtask

   task automatic t_oe_pulses;
      logic [7:0] exp;
      @(negedge clk);
      addr = 15'h0200; ce_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         oe_n = 1'b0; tgl_m = ~tgl_m; exp = expect_busy(15'h0200, tgl_m);
         @(posedge clk); #1;
         check("R5 oe start", rd_data, exp);
         @(negedge clk);
         oe_n = 1'b1;
      end
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic t_busy_restart;
      @(negedge clk);
      busy = 1'b0; array_data = 8'h81;
      do_read(15'h0123, "R7 done true data");
      @(negedge clk);
      busy = 1'b1; tgl_m = 1'b0; last_data = 8'h00;
      do_read(15'h0123, "R7 flag restarts");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset;
      t_idle_reads;
      t_write_strobe;
      t_poll;
      t_held_read;
      t_write_between_polls;
      t_oe_pulses;
      t_busy_restart;
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule